// File: doc/BRIEF.md
# Stereo Volume Attenuation Register File

This block holds the digital volume attenuation for a left and a right audio channel. Each channel's attenuation is a 10-bit code. Software writes it as two 5-bit halves at two separate addresses. The low half counts in 0.125 dB steps and the high half counts in 4 dB steps, so a code of zero means 0 dB.

Every write lands only in a staging register. The active attenuation outputs stay as they are until a write carries the commit flag. That write copies all four staged halves to the outputs of both channels on one clock edge. The value written in the committing cycle is itself part of the committed set.

A combinational read port returns the staged value at the addressed location.

Top module: `atten_regs`

## Requirements
- R1: After reset, all four staged fields read back as 0, and both active outputs `left_atten` and `right_atten` are 0.
- R2: A write with data bit 5 (the commit flag) clear updates only the staged field at its address. Both active outputs are unchanged on the following cycle.
- R3: A write to addresses 0 to 3 with data bit 5 set copies all four staged fields to both active outputs on the same clock edge. This includes the fields of the channel that was not addressed.
- R4: The code is composed as follows. Address 0 supplies `left_atten[4:0]` and address 1 supplies `left_atten[9:5]`. Address 2 supplies `right_atten[4:0]` and address 3 supplies `right_atten[9:5]`. Each field is taken from data bits [4:0].
- R5: On a committing write, the outputs take the data written in that same cycle for its address, not the previously staged value.
- R6: The commit flag is not stored. `rdata` for addresses 0 to 3 has bit 5 equal to 0 and bits [4:0] equal to the staged field. For any other address, `rdata` is 0.
- R7: A write to an address from 4 upward changes no staged field and no output, even when bit 5 is set.
- R8: With `wr_en` low, the address and data inputs have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (3) | Register address for writing and reading |
| wdata | input | FIELD_W+1 (6) | Bit 5 is the commit flag; bits [4:0] are the field |
| rdata | output | FIELD_W+1 (6) | Staged field at `addr`, with bit 5 always 0 |
| left_atten | output | 2*FIELD_W (10) | Active left attenuation code |
| right_atten | output | 2*FIELD_W (10) | Active right attenuation code |

## Verification
The hardest case to reach is a commit write whose address already holds a different staged value. Only there does the same-cycle bypass show at the outputs. The stimulus first stages a known value, then commits a different value to the same address, and compares against a model that applies the write before the copy. Long random streams mix staged writes, commits, out-of-range writes with the flag set, and idle cycles carrying live data. This exposes any partial commit or stale value.

// File: rtl/atten_regs.sv
module atten_regs #(
  parameter int FIELD_W = 5,
  parameter int ADDR_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [FIELD_W:0]     wdata,
  output logic [FIELD_W:0]     rdata,
  output logic [2*FIELD_W-1:0] left_atten,
  output logic [2*FIELD_W-1:0] right_atten
);
  localparam int NREG = 4;

  logic [NREG-1:0][FIELD_W-1:0] stg_q, stg_d;
  logic in_range, commit;

  assign in_range = (addr < ADDR_W'(NREG));
  assign commit   = wr_en && in_range && wdata[FIELD_W];

  always_comb begin
    stg_d = stg_q;
    if (wr_en && in_range) stg_d[addr[1:0]] = wdata[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q       <= '0;
      left_atten  <= '0;
      right_atten <= '0;
    end else begin
      stg_q <= stg_d;
      if (commit) begin
        left_atten  <= {stg_d[1], stg_d[0]};
        right_atten <= {stg_d[3], stg_d[2]};
      end
    end
  end

  assign rdata = in_range ? {1'b0, stg_q[addr[1:0]]} : '0;

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(left_atten) && $stable(right_atten)); // R2
  AST_COMMIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> left_atten == {stg_q[1], stg_q[0]} && right_atten == {stg_q[3], stg_q[2]}); // R3
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == 0) |=> left_atten[FIELD_W-1:0] == $past(wdata[FIELD_W-1:0])); // R5
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(stg_q) && $stable(left_atten) && $stable(right_atten)); // R7
  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stg_q)); // R8
  always_comb AST_RDATA_FLAG_ZERO: assert (rdata[FIELD_W] == 1'b0); // R6
endmodule

// File: tb/atten_regs_test.sv
module atten_regs_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [5:0] wdata = 0;
  logic [5:0] rdata;
  logic [9:0] left_atten, right_atten;
  int tests = 0, fails = 0;
  int stg_m [4];
  int l_m = 0, r_m = 0;
  bit done = 0;

  always #5 clk = ~clk;

  atten_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                  .rdata(rdata), .left_atten(left_atten), .right_atten(right_atten));

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(bit we, int a, int d, string tag);
    @(negedge clk);
    wr_en = we; addr = 3'(a); wdata = 6'(d);
    #1;
    check("R6 readback", int'(rdata), (a < 4) ? stg_m[a] : 0);
    @(posedge clk);
    if (we && a < 4) begin
      stg_m[a] = d & 31;
      if (d & 32) begin
        l_m = stg_m[1] * 32 + stg_m[0];
        r_m = stg_m[3] * 32 + stg_m[2];
      end
    end
    #2;
    check({tag, " left"}, int'(left_atten), l_m);
    check({tag, " right"}, int'(right_atten), r_m);
  endtask

  initial begin
    foreach (stg_m[i]) stg_m[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 left", int'(left_atten), 0);
    check("R1 right", int'(right_atten), 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) step(0, a, 0, "R1");
    step(1, 0, 5'd7, "R2");
    step(1, 1, 5'd3, "R2");
    step(1, 2, 5'd31, "R2");
    step(1, 3, 5'd16, "R2");
    step(1, 1, 32 + 3, "R3 R4");
    check("R4 left exact", int'(left_atten), 3 * 32 + 7);
    check("R4 right exact", int'(right_atten), 16 * 32 + 31);
    step(1, 2, 5'd9, "R5 stage");
    step(1, 2, 32 + 21, "R5 bypass");
    check("R5 right low", int'(right_atten[4:0]), 21);
    step(1, 5, 32 + 1, "R7");
    step(1, 7, 32 + 30, "R7");
    step(0, 0, 32 + 17, "R8");
    step(0, 3, 63, "R8");
    step(1, 0, 32 + 4, "R3 after R8");
    for (int i = 0; i < 2000; i++) begin
      int a = $urandom_range(0, 7);
      int d = $urandom_range(0, 63);
      bit we = ($urandom_range(0, 3) != 0);
      step(we, a, d, "R3 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule